// File: doc/BRIEF.md
# Sector Buffer Manager

This block sits between a host bus and an external byte-wide sector buffer that is also used by a disk controller. The host programs a buffer length and issues a command through a small register file. The block then runs the transfer in phases. First it loads the buffer start address into an external counter. Then either the host moves bytes through the data port, with DRQ as the pacing signal, or the block offers the buffer to the disk controller and waits for the controller's busy handshake to finish. At the end it raises INTRQ.

Three commands exist. A fill command lets the host write one buffer length of bytes, then hands the full buffer to the controller. A fetch command first hands the empty buffer to the controller, then lets the host read the bytes back. A copy-fetch command runs only the controller phase and never asks the host for data. Every byte the host moves selects the RAM and then advances the external address counter with one low pulse.

Top module: `secbuf_mgr`

## Requirements
- R1: After reset, drq, intrq, buf_ready, addr_le, ram_cs and bus_oe are low, cnt_inc_n is high, the status register reads 0x00 and the size register reads 0x01.
- R2: The host register address selects the data port at 0, the size register at 3 (read/write) and command (write) / status (read) at 7. Status bits: bit 7 busy, bit 3 DRQ, bit 1 done, bit 0 error. All other status bits read 0.
- R3: A command write to address 7 starts execution at once, and busy reads 1 on the next status read. While the block is busy, writes to the size and command registers are ignored.
- R4: The transfer length is the size register value times 128, and a value of 0 gives 32768 bytes. DRQ stays high for exactly that many accepted data-port accesses.
- R5: DRQ is high only during a host phase. Fill (command upper nibble 0x1) takes host writes before the controller phase. Fetch (0x2) takes host reads after the controller phase. Only accesses in the command's direction are accepted.
- R6: Each accepted data byte asserts ram_cs in its access cycle, puts the host byte on bus_out with bus_oe for writes, and returns bus_in on host_rdata for reads. It also drives cnt_inc_n low for the following cycle.
- R7: Each phase begins with two addr_le cycles that drive the base address onto bus_out, high byte first and low byte second. The default base address is 0.
- R8: buf_ready is high while the buffer is offered to the controller, which happens when it is full after a fill or empty at the start of a fetch. It drops once ctl_busy is seen high, and the controller phase ends when ctl_busy falls.
- R9: While ctl_busy is high, bus_oe, ram_cs and addr_le are low and cnt_inc_n is high. A host data access made then is dropped.
- R10: A copy-fetch (command upper nibble 0x3) completes after the controller phase without ever raising DRQ.
- R11: INTRQ rises in the cycle after a command completes. It is cleared by a status read or by a new command write. An unknown command upper nibble completes at once with done and error set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| drq | output | 1 | Data request to host |
| intrq | output | 1 | Interrupt request to host |
| ctl_busy | input | 1 | Disk controller owns the buffer |
| buf_ready | output | 1 | Buffer offered to the controller |
| addr_le | output | 1 | External address latch enable |
| ram_cs | output | 1 | Buffer RAM select |
| cnt_inc_n | output | 1 | External counter increment, active on falling edge |
| bus_out | output | 8 | Shared bus drive value |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | 8 | Shared bus read value |

## Verification
A wrong phase state shows up at the ports at once. DRQ or buf_ready rises at the wrong time, or addr_le appears without a following pair. A copy-fetch that raises DRQ is also a symptom. A miscounted byte counter moves the DRQ fall one access early or late, and the 127/128 and 32767/32768 boundaries expose this within one access. Bad strobe gating either drives the bus while ctl_busy is high or leaves the external address out of step with the bytes. Either fault shows as a wrong byte at a wrong buffer address, and the scoreboard flags it on the next transfer.

// File: rtl/secbuf_pkg.sv
package secbuf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LD_A,
      ST_LD_B,
      ST_HOST,
      ST_CWAIT,
      ST_CRUN
   } seq_st_t;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_FILL,
      OP_FETCH,
      OP_COPY
   } op_t;

   localparam logic [2:0] RA_DATA = 3'd0;
   localparam logic [2:0] RA_SIZE = 3'd3;
   localparam logic [2:0] RA_CMD  = 3'd7;

   localparam int SB_BUSY = 7;
   localparam int SB_DRQ  = 3;
   localparam int SB_DONE = 1;
   localparam int SB_ERR  = 0;

   function automatic op_t decode_op(input logic [3:0] nib);
      case (nib)
         4'h1:    return OP_FILL;
         4'h2:    return OP_FETCH;
         4'h3:    return OP_COPY;
         default: return OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/secbuf_regs.sv
module secbuf_regs
   import secbuf_pkg::*;
#(
   parameter int SIZE_W   = 8,
   parameter int SIZE_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [2:0]        host_addr,
   input  logic [7:0]        host_wdata,
   input  logic [7:0]        bus_in,
   input  logic              busy,
   input  logic              drq,
   input  logic              fin,
   input  logic              fin_err,
   output logic [7:0]        host_rdata,
   output logic              cmd_go,
   output op_t               cmd_op,
   output logic [SIZE_W-1:0] size_q,
   output logic              intrq
);

   logic wr_ok;
   logic stat_rd;
   logic done_q;
   logic err_q;
   logic [7:0] stat_byte;

   assign wr_ok   = host_cs & host_wr & ~busy;
   assign cmd_go  = wr_ok & (host_addr == RA_CMD);
   assign cmd_op  = decode_op(host_wdata[7:4]);
   assign stat_rd = host_cs & host_rd & (host_addr == RA_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= SIZE_W'(SIZE_RST);
      end else if (wr_ok && host_addr == RA_SIZE) begin
         size_q <= host_wdata[SIZE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intrq  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (fin) begin
            intrq  <= 1'b1;
            done_q <= 1'b1;
            err_q  <= fin_err;
         end else if (cmd_go) begin
            intrq  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (stat_rd) begin
            intrq  <= 1'b0;
         end
      end
   end

   always_comb begin
      stat_byte          = 8'h00;
      stat_byte[SB_BUSY] = busy;
      stat_byte[SB_DRQ]  = drq;
      stat_byte[SB_DONE] = done_q;
      stat_byte[SB_ERR]  = err_q;
   end

   always_comb begin
      case (host_addr)
         RA_DATA: host_rdata = bus_in;
         RA_SIZE: host_rdata = 8'(size_q);
         RA_CMD:  host_rdata = stat_byte;
         default: host_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/secbuf_seq.sv
module secbuf_seq
   import secbuf_pkg::*;
#(
   parameter int SIZE_W    = 8,
   parameter int UNIT_LOG2 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  op_t               cmd_op,
   input  logic [SIZE_W-1:0] size_q,
   input  logic              ctl_busy,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [2:0]        host_addr,
   output seq_st_t           state,
   output logic              busy,
   output logic              drq,
   output logic              acc,
   output logic              acc_wr,
   output logic              fin,
   output logic              fin_err,
   output logic              buf_ready
);

   localparam int SPAN_W = SIZE_W + UNIT_LOG2;
   localparam int LEN_W  = SPAN_W + 1;

   op_t              op_q;
   logic             second_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_new;
   logic             last;
   logic             host_first;

   always_comb begin
      if (size_q == '0) len_new = LEN_W'(1) << SPAN_W;
      else              len_new = LEN_W'(size_q) << UNIT_LOG2;
   end

   assign busy       = (state != ST_IDLE);
   assign drq        = (state == ST_HOST);
   assign buf_ready  = (state == ST_CWAIT);
   assign acc_wr     = (op_q == OP_FILL);
   assign acc        = drq & host_cs & (host_addr == RA_DATA) & ~ctl_busy
                       & (acc_wr ? host_wr : host_rd);
   assign last       = acc & (LEN_W'(cnt_q + 1'b1) == len_q);
   assign host_first = (op_q == OP_FILL && !second_q) ||
                       (op_q == OP_FETCH && second_q);

   assign fin_err = cmd_go & ~busy & (cmd_op == OP_NONE);
   assign fin     = fin_err
                  | (last & (op_q == OP_FETCH))
                  | ((state == ST_CRUN) & ~ctl_busy & (op_q != OP_FETCH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_q     <= OP_NONE;
         second_q <= 1'b0;
         len_q    <= '0;
         cnt_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_go && cmd_op != OP_NONE) begin
                  state    <= ST_LD_A;
                  op_q     <= cmd_op;
                  second_q <= 1'b0;
                  len_q    <= len_new;
               end
            end
            ST_LD_A: begin
               if (!ctl_busy) state <= ST_LD_B;
            end
            ST_LD_B: begin
               if (!ctl_busy) begin
                  cnt_q <= '0;
                  state <= host_first ? ST_HOST : ST_CWAIT;
               end
            end
            ST_HOST: begin
               if (acc) cnt_q <= LEN_W'(cnt_q + 1'b1);
               if (last) begin
                  if (op_q == OP_FILL) begin
                     state    <= ST_LD_A;
                     second_q <= 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_CWAIT: begin
               if (ctl_busy) state <= ST_CRUN;
            end
            ST_CRUN: begin
               if (!ctl_busy) begin
                  if (op_q == OP_FETCH) begin
                     state    <= ST_LD_A;
                     second_q <= 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/secbuf_bus.sv
module secbuf_bus
   import secbuf_pkg::*;
#(
   parameter int BASE_ADDR = 0,
   parameter bit HI_FIRST  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_st_t    state,
   input  logic       acc,
   input  logic       acc_wr,
   input  logic [7:0] host_wdata,
   input  logic       ctl_busy,
   output logic       addr_le,
   output logic       ram_cs,
   output logic       cnt_inc_n,
   output logic [7:0] bus_out,
   output logic       bus_oe
);

   localparam logic [15:0] BASE_V = 16'(BASE_ADDR);

   logic [7:0] byte_a;
   logic [7:0] byte_b;
   logic       ld;
   logic       inc_q;

   generate
      if (HI_FIRST) begin : g_hi_first
         assign byte_a = BASE_V[15:8];
         assign byte_b = BASE_V[7:0];
      end else begin : g_lo_first
         assign byte_a = BASE_V[7:0];
         assign byte_b = BASE_V[15:8];
      end
   endgenerate

   assign ld      = (state == ST_LD_A) || (state == ST_LD_B);
   assign addr_le = ld & ~ctl_busy;
   assign ram_cs  = acc;
   assign bus_oe  = ~ctl_busy & (ld | (acc & acc_wr));

   always_comb begin
      if (state == ST_LD_A)      bus_out = byte_a;
      else if (state == ST_LD_B) bus_out = byte_b;
      else                       bus_out = host_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inc_q <= 1'b1;
      else        inc_q <= ~acc;
   end

   assign cnt_inc_n = inc_q | ctl_busy;

endmodule

// File: rtl/secbuf_mgr.sv
module secbuf_mgr
   import secbuf_pkg::*;
#(
   parameter int SIZE_W    = 8,
   parameter int UNIT_LOG2 = 7,
   parameter int SIZE_RST  = 1,
   parameter int BASE_ADDR = 0,
   parameter bit HI_FIRST  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_cs,
   input  logic       host_rd,
   input  logic       host_wr,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       drq,
   output logic       intrq,
   input  logic       ctl_busy,
   output logic       buf_ready,
   output logic       addr_le,
   output logic       ram_cs,
   output logic       cnt_inc_n,
   output logic [7:0] bus_out,
   output logic       bus_oe,
   input  logic [7:0] bus_in
);

   generate
      if (SIZE_W < 1 || SIZE_W > 8) begin : g_bad_size
         $error("SIZE_W must lie in 1..8");
      end
      if (SIZE_W + UNIT_LOG2 > 16) begin : g_bad_span
         $error("buffer span exceeds 16 address bits");
      end
   endgenerate

   seq_st_t           state;
   op_t               cmd_op;
   logic              cmd_go;
   logic [SIZE_W-1:0] size_q;
   logic              busy;
   logic              acc;
   logic              acc_wr;
   logic              fin;
   logic              fin_err;

   secbuf_regs #(.SIZE_W(SIZE_W), .SIZE_RST(SIZE_RST)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .bus_in(bus_in),
      .busy(busy), .drq(drq), .fin(fin), .fin_err(fin_err),
      .host_rdata(host_rdata), .cmd_go(cmd_go), .cmd_op(cmd_op),
      .size_q(size_q), .intrq(intrq)
   );

   secbuf_seq #(.SIZE_W(SIZE_W), .UNIT_LOG2(UNIT_LOG2)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_go(cmd_go), .cmd_op(cmd_op), .size_q(size_q),
      .ctl_busy(ctl_busy),
      .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
      .host_addr(host_addr),
      .state(state), .busy(busy), .drq(drq), .acc(acc), .acc_wr(acc_wr),
      .fin(fin), .fin_err(fin_err), .buf_ready(buf_ready)
   );

   secbuf_bus #(.BASE_ADDR(BASE_ADDR), .HI_FIRST(HI_FIRST)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .state(state), .acc(acc), .acc_wr(acc_wr),
      .host_wdata(host_wdata), .ctl_busy(ctl_busy),
      .addr_le(addr_le), .ram_cs(ram_cs), .cnt_inc_n(cnt_inc_n),
      .bus_out(bus_out), .bus_oe(bus_oe)
   );

endmodule

// File: rtl/secbuf_chk.sv
module secbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_busy,
   input logic bus_oe,
   input logic ram_cs,
   input logic addr_le,
   input logic cnt_inc_n,
   input logic drq,
   input logic buf_ready,
   input logic intrq,
   input logic busy
);

   a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_busy |-> (!bus_oe && !ram_cs && !addr_le && cnt_inc_n));

   a_r6_inc_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |=> (!cnt_inc_n || ctl_busy));

   a_r5_cs_in_drq: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> drq);

   a_r8_ready_excl_drq: assert property (@(posedge clk) disable iff (!rst_n)
      buf_ready |-> !drq);

   a_r11_intrq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> intrq);

   a_r7_le_paired: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_le) |=> (addr_le || ctl_busy));

   a_r7_le_drives: assert property (@(posedge clk) disable iff (!rst_n)
      addr_le |-> bus_oe);

endmodule

bind secbuf_mgr secbuf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_busy(ctl_busy), .bus_oe(bus_oe),
   .ram_cs(ram_cs), .addr_le(addr_le), .cnt_inc_n(cnt_inc_n),
   .drq(drq), .buf_ready(buf_ready), .intrq(intrq), .busy(busy)
);

// File: tb/tb_secbuf_mgr.sv
module tb_secbuf_mgr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       drq, intrq, buf_ready, addr_le, ram_cs, cnt_inc_n, bus_oe;
   logic       ctl_busy = 1'b0;
   logic [7:0] bus_out, bus_in;

   always #5 clk = ~clk;

   secbuf_mgr dut (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .drq(drq), .intrq(intrq),
      .ctl_busy(ctl_busy), .buf_ready(buf_ready), .addr_le(addr_le),
      .ram_cs(ram_cs), .cnt_inc_n(cnt_inc_n), .bus_out(bus_out),
      .bus_oe(bus_oe), .bus_in(bus_in)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int drq_cnt = 0;
   bit mon_en = 1'b0;
   logic [7:0]  mem [256];
   logic [15:0] ext_addr = 16'h7fff;
   logic        le_prev = 1'b0;
   logic        inc_prev = 1'b1;
   logic [7:0]  wq [$];
   logic [15:0] aq [$];

   assign bus_in = mem[ext_addr[7:0]];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 7 + 3);
   endfunction

   // monitor: external counter model, buffer RAM and write scoreboard
   always @(posedge clk) begin
      if (addr_le) begin
         if (!le_prev) ext_addr[15:8] <= bus_out;
         else          ext_addr[7:0]  <= bus_out;
      end else if (inc_prev && !cnt_inc_n) begin
         ext_addr <= ext_addr + 16'd1;
      end
      le_prev  <= addr_le;
      inc_prev <= cnt_inc_n;
      if (drq) drq_cnt <= drq_cnt + 1;
      if (ram_cs && bus_oe) begin
         mem[ext_addr[7:0]] <= bus_out;
         if (mon_en) begin
            if (wq.size() == 0) chk("R9 unexpected buffer write", 32'd1, 32'd0);
            else begin
               chk("R6 written byte", 32'(bus_out), 32'(wq.pop_front()));
               chk("R7 written address", 32'(ext_addr), 32'(aq.pop_front()));
            end
         end
      end
   end

   task automatic hwr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_cs = 1'b0; host_rd = 1'b0;
   endtask

   task automatic wait_drq();
      for (int t = 0; t < 100 && !drq; t++) @(negedge clk);
      chk("R5 drq rises for host phase", 32'(drq), 32'd1);
   endtask

   task automatic ctl_phase(input logic exp_intrq);
      for (int t = 0; t < 100 && !buf_ready; t++) @(negedge clk);
      chk("R8 buf_ready offered", 32'(buf_ready), 32'd1);
      chk("R8 no drq while offered", 32'(drq), 32'd0);
      @(negedge clk); ctl_busy = 1'b1;
      @(negedge clk);
      #1;
      chk("R8 buf_ready drops", 32'(buf_ready), 32'd0);
      host_cs = 1'b1; host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'hee;
      #1;
      chk("R9 ram_cs off while busy", 32'(ram_cs), 32'd0);
      chk("R9 bus_oe off while busy", 32'(bus_oe), 32'd0);
      chk("R9 cnt_inc_n high while busy", 32'(cnt_inc_n), 32'd1);
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0;
      repeat (3) @(negedge clk);
      ctl_busy = 1'b0;
      @(negedge clk);
      #1;
      chk("R11 intrq after controller phase", 32'(intrq), 32'(exp_intrq));
   endtask

   initial begin
      #1_500_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int dc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 drq", 32'(drq), 32'd0);
      chk("R1 intrq", 32'(intrq), 32'd0);
      chk("R1 buf_ready", 32'(buf_ready), 32'd0);
      chk("R1 cnt_inc_n", 32'(cnt_inc_n), 32'd1);
      chk("R1 addr_le", 32'(addr_le), 32'd0);
      hrd(3'd7, d); chk("R1 status", 32'(d), 32'h00);
      hrd(3'd3, d); chk("R1 size", 32'(d), 32'h01);

      // fill command, 128 bytes
      mon_en = 1'b1;
      hwr(3'd3, 8'd1);
      hwr(3'd7, 8'h10);
      hrd(3'd7, d); chk("R3 R2 busy status", 32'(d), 32'h80);
      hwr(3'd3, 8'd5);
      hwr(3'd7, 8'h20);
      wait_drq();
      chk("R7 base address latched", 32'(ext_addr), 32'd0);
      hrd(3'd7, d); chk("R2 status with drq", 32'(d), 32'h88);
      for (int i = 0; i < 128; i++) begin
         wq.push_back(pat(i));
         aq.push_back(16'(i));
         if (i == 127) chk("R4 drq before last byte", 32'(drq), 32'd1);
         hwr(3'd0, pat(i));
      end
      chk("R4 drq after 128 bytes", 32'(drq), 32'd0);
      ctl_phase(1'b1);
      chk("R6 all bytes written", 32'(wq.size()), 32'd0);
      hrd(3'd7, d); chk("R11 R2 done status", 32'(d), 32'h02);
      chk("R11 status read clears intrq", 32'(intrq), 32'd0);
      hrd(3'd3, d); chk("R3 size write ignored while busy", 32'(d), 32'h01);

      // fetch command reads the buffer back
      hwr(3'd7, 8'h20);
      ctl_phase(1'b0);
      wait_drq();
      chk("R7 base address for fetch", 32'(ext_addr), 32'd0);
      hrd(3'd7, d); chk("R5 wrong-direction probe status", 32'(d), 32'h88);
      hwr(3'd0, 8'h55);
      chk("R5 wrong-direction write dropped", 32'(ext_addr), 32'd0);
      for (int i = 0; i < 128; i++) begin
         hrd(3'd0, d);
         chk("R6 read byte", 32'(d), 32'(pat(i)));
      end
      chk("R4 drq off after fetch", 32'(drq), 32'd0);
      chk("R11 intrq after fetch", 32'(intrq), 32'd1);

      // copy-fetch: no drq at all
      dc = drq_cnt;
      hwr(3'd7, 8'h30);
      chk("R11 command write clears intrq", 32'(intrq), 32'd0);
      ctl_phase(1'b1);
      chk("R10 no drq in copy-fetch", 32'(drq_cnt), 32'(dc));

      // illegal command
      hrd(3'd7, d);
      hwr(3'd7, 8'h70);
      chk("R11 illegal completes", 32'(intrq), 32'd1);
      hrd(3'd7, d); chk("R11 illegal error status", 32'(d), 32'h03);

      // size 0 means 32768 bytes
      mon_en = 1'b0;
      hwr(3'd3, 8'd0);
      hwr(3'd7, 8'h10);
      wait_drq();
      for (int i = 0; i < 32768; i++) begin
         if (i == 32767) chk("R4 drq before byte 32768", 32'(drq), 32'd1);
         hwr(3'd0, 8'(i));
      end
      chk("R4 drq off after 32768", 32'(drq), 32'd0);
      ctl_phase(1'b1);
      hrd(3'd3, d); chk("R2 size reads zero", 32'(d), 32'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule